// File: doc/BRIEF.md
# Dual-format serial audio receiver

This block turns a three-wire stereo PCM stream (bit clock, frame-sync line, data line) into parallel left and right samples inside a faster system clock domain. All three wires are double-registered. Data is taken on each rising bit-clock edge that the block detects.

Two framings are accepted. In the I2S-style framing, the word starts one bit after the frame-sync change and runs MSB first. In the right-justified ("normal") framing, the word ends on the last bit before the frame-sync change. Words are 16 or 18 bits of two's complement. Every finished word appears on an 18-bit output of its channel, with a one-cycle valid strobe. A hardware-pin mode input overrides the control inputs and fixes the block to 16-bit right-justified framing with default channel polarity.

Top module: `serial_pcm_rx`

## Requirements
- R1: Data and frame-sync are sampled only on rising bit-clock edges seen in the system clock domain. Each valid strobe follows such an edge.
- R2: In I2S framing (fmt_i2s=1), the bit on the first rising edge after a frame-sync change is dropped. The MSB is taken on the second rising edge, and the next N-1 edges carry the rest of the word. The strobe fires when the Nth bit is taken, and any further bits in the half-frame are ignored.
- R3: In I2S framing, frame-sync low carries the left channel and high carries the right channel, and lr_swap has no effect.
- R4: In right-justified framing (fmt_i2s=0), the word is the last N bits received before the frame-sync change, MSB first. Earlier bits in the half-frame are discarded. The strobe fires on the first rising edge that sees the change.
- R5: In right-justified framing with lr_swap=0, a half-frame with frame-sync high is left and low is right. With lr_swap=1 the mapping is reversed.
- R6: N is 18 when word18=1 and 16 when word18=0. An 18-bit word fills data bits 17:0. A 16-bit word occupies bits 17:2, and bits 1:0 are zero.
- R7: When hw_mode=1, the block behaves as right-justified, 16-bit, lr_swap=0, whatever fmt_i2s, word18 and lr_swap hold.
- R8: A valid strobe lasts exactly one system cycle, and the two strobes never fire together. Each data output holds its value until its own next strobe.
- R9: An active-low reset clears both data outputs and both strobes. After reset, no word is produced until a frame-sync change has been seen. In right-justified framing, the half-frame that ends at the first change produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | Forces 16-bit right-justified, default polarity |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = right-justified |
| word18 | input | 1 | 1 = 18-bit words, 0 = 16-bit words |
| lr_swap | input | 1 | Swaps channel polarity in right-justified framing |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame-sync / channel-select line |
| sdata | input | 1 | Serial data line |
| left_data | output | 18 | Last left-channel word, left-aligned |
| left_valid | output | 1 | One-cycle strobe for a new left word |
| right_data | output | 18 | Last right-channel word, left-aligned |
| right_valid | output | 1 | One-cycle strobe for a new right word |

## Verification
The hardest case to reach is a right-justified half-frame that is longer than the word. In that case the leading filler bits must fall out of the shift register, and the word is only committed at the following frame-sync edge. The stimulus sends half-frames of 16 to 32 slots with alternating filler ahead of the word, then ends with one extra slot of the opposite channel so the last word gets flushed. A leading filler half-frame after each reset checks that the first frame-sync change produces nothing. Each vector's configuration is applied under reset, and then exactly one word per channel is expected.

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx #(
  parameter int W_LONG  = 18,
  parameter int W_SHORT = 16,
  parameter int SYNC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_mode,
  input  logic              fmt_i2s,
  input  logic              word18,
  input  logic              lr_swap,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              sdata,
  output logic [W_LONG-1:0] left_data,
  output logic              left_valid,
  output logic [W_LONG-1:0] right_data,
  output logic              right_valid
);

  localparam int PAD = W_LONG - W_SHORT;
  localparam int CW  = $clog2(W_LONG + 2);
  localparam logic [CW-1:0] CNT_IDLE = CW'(W_LONG + 1);

  logic [SYNC:0]   bclk_q;
  logic [SYNC-1:0] fs_q, sd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_q <= '0;
      fs_q   <= '0;
      sd_q   <= '0;
    end else begin
      bclk_q <= {bclk_q[SYNC-1:0], bclk};
      fs_q   <= {fs_q[SYNC-2:0], fsync};
      sd_q   <= {sd_q[SYNC-2:0], sdata};
    end

  wire rise   = bclk_q[SYNC-1] & ~bclk_q[SYNC];
  wire fs_now = fs_q[SYNC-1];
  wire sd_now = sd_q[SYNC-1];

  wire use_i2s = fmt_i2s & ~hw_mode;
  wire use18   = word18 & ~hw_mode;
  wire swap    = lr_swap & ~hw_mode & ~use_i2s;
  wire [CW-1:0] n_bits = use18 ? CW'(W_LONG) : CW'(W_SHORT);

  logic              seen, primed, fs_prev;
  logic [W_LONG-1:0] sr;
  logic [CW-1:0]     cnt;

  wire [W_LONG-1:0] shifted = {sr[W_LONG-2:0], sd_now};
  wire chg = seen & (fs_now ^ fs_prev);

  function automatic logic [W_LONG-1:0] align(input logic [W_LONG-1:0] w, input logic l18);
    return l18 ? w : {w[W_SHORT-1:0], {PAD{1'b0}}};
  endfunction

  wire emit_rj  = rise & chg & primed & ~use_i2s;
  wire emit_i2s = rise & ~chg & use_i2s & (cnt == n_bits - CW'(1));
  wire emit     = emit_rj | emit_i2s;
  wire [W_LONG-1:0] emit_word = align(use_i2s ? shifted : sr, use18);
  wire emit_left = use_i2s ? ~fs_now : (fs_prev ^ swap);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen    <= 1'b0;
      primed  <= 1'b0;
      fs_prev <= 1'b0;
      sr      <= '0;
      cnt     <= CNT_IDLE;
    end else if (rise) begin
      seen    <= 1'b1;
      fs_prev <= fs_now;
      if (chg) primed <= 1'b1;
      if (use_i2s) begin
        if (chg) begin
          cnt <= '0;
          sr  <= '0;
        end else if (cnt < n_bits) begin
          cnt <= cnt + CW'(1);
          sr  <= shifted;
        end
      end else begin
        sr  <= shifted;
        cnt <= CNT_IDLE;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      left_data   <= '0;
      right_data  <= '0;
    end else begin
      left_valid  <= emit & emit_left;
      right_valid <= emit & ~emit_left;
      if (emit & emit_left)  left_data  <= emit_word;
      if (emit & ~emit_left) right_data <= emit_word;
    end

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_valid && right_valid)); // R8
  AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |=> !left_valid); // R8
  AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |=> !right_valid); // R8
  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !left_valid |-> $stable(left_data)); // R8
  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !right_valid |-> $stable(right_data)); // R8
  AST_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid) |-> $past(rise)); // R1
  AST_SHORT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid && !$past(use18)) |-> left_data[PAD-1:0] == '0); // R6
  AST_HW_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (right_valid && $past(hw_mode)) |-> right_data[PAD-1:0] == '0); // R7

endmodule

// File: tb/sim_serial_pcm_rx.sv
`timescale 1ns/1ps
module sim_serial_pcm_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_mode = 0, fmt_i2s = 0, word18 = 0, lr_swap = 0;
  logic bclk = 0, fsync = 0, sdata = 0;
  logic [17:0] left_data, right_data;
  logic left_valid, right_valid;

  always #2 clk = ~clk;

  serial_pcm_rx u0 (.clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .fmt_i2s(fmt_i2s),
    .word18(word18), .lr_swap(lr_swap), .bclk(bclk), .fsync(fsync), .sdata(sdata),
    .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid));

  int checks = 0, errs = 0;
  int nl = 0, nr = 0, wide = 0, both = 0;
  logic [17:0] last_l = '0, last_r = '0;
  logic plv = 0, prv = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (left_valid)  begin nl++; last_l = left_data; end
      if (right_valid) begin nr++; last_r = right_data; end
      if ((left_valid && plv) || (right_valid && prv)) wide++;
      if (left_valid && right_valid) both++;
    end
    plv = left_valid; prv = right_valid;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R1: each slot sets fsync/sdata while bclk is low, then raises bclk
  task automatic slot(input logic ws, input logic b);
    @(negedge clk); fsync = ws; sdata = b;
    repeat (8) @(negedge clk); bclk = 1'b1;
    repeat (8) @(negedge clk); bclk = 1'b0;
  endtask

  task automatic half(input logic ws, input logic [17:0] w, input int k, input logic i2s, input int n);
    for (int s = 0; s < k; s++) begin
      logic b;
      b = s[0];
      if (!i2s && s >= k - n) b = w[n - 1 - (s - (k - n))];
      if (i2s && s >= 1 && s <= n) b = w[n - s];
      slot(ws, b);
    end
  endtask

  // {i2s, w18, swap, hw, s0, K[5:0], A[17:0], B[17:0]}
  localparam logic [46:0] VEC [8] = '{
    {1'b0,1'b0,1'b0,1'b0,1'b0,6'd16,18'h1234B,18'h3FFFF},
    {1'b0,1'b1,1'b0,1'b0,1'b1,6'd24,18'h20000,18'h00001},
    {1'b0,1'b1,1'b1,1'b0,1'b0,6'd18,18'h2AAAA,18'h15555},
    {1'b0,1'b0,1'b1,1'b0,1'b1,6'd32,18'h08000,18'h0C3A5},
    {1'b1,1'b0,1'b0,1'b0,1'b1,6'd17,18'h0FFFF,18'h08001},
    {1'b1,1'b1,1'b1,1'b0,1'b0,6'd32,18'h3FFFF,18'h20001},
    {1'b1,1'b1,1'b0,1'b1,1'b1,6'd20,18'h3ABCD,18'h21357},
    {1'b0,1'b1,1'b1,1'b1,1'b0,6'd18,18'h1F0F0,18'h3C3C3}
  };

  function automatic logic [17:0] expw(input logic [17:0] w, input int n);
    return (n == 18) ? w : {w[15:0], 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R9 reset left_data", left_data, 0);
    chk("R9 reset right_data", right_data, 0);
    chk("R9 reset strobes", {left_valid, right_valid}, 0);
    for (int v = 0; v < 8; v++) begin
      logic i2s, w18, sw, hw, s0, ei2s, epol, a_left;
      int k, n, l0, r0;
      logic [17:0] a, b, el, er;
      string tag;
      {i2s, w18, sw, hw, s0} = VEC[v][46:42];
      k = int'(VEC[v][41:36]); a = VEC[v][35:18]; b = VEC[v][17:0];
      @(negedge clk); rst_n = 1'b0;
      hw_mode = hw; fmt_i2s = i2s; word18 = w18; lr_swap = sw;
      fsync = 1'b0; sdata = 1'b0; bclk = 1'b0;
      repeat (4) @(negedge clk); rst_n = 1'b1;
      ei2s = i2s & ~hw; n = (w18 & ~hw) ? 18 : 16; epol = sw & ~hw & ~ei2s;
      a_left = ei2s ? (~s0 == 1'b0) : (((~s0) ^ epol) == 1'b1);
      el = a_left ? expw(a, n) : expw(b, n);
      er = a_left ? expw(b, n) : expw(a, n);
      tag = hw ? "R7" : (ei2s ? "R2 R3 R6" : "R4 R5 R6");
      l0 = nl; r0 = nr;
      half(s0, 18'h3FFFF, k, ei2s, n);
      half(~s0, a, k, ei2s, n);
      half(s0, b, k, ei2s, n);
      slot(~s0, 1'b0);
      repeat (20) @(negedge clk);
      chk({tag, " left word"}, last_l, el);
      chk({tag, " right word"}, last_r, er);
      chk("R9 R8 left word count", nl - l0, 1);
      chk("R9 R8 right word count", nr - r0, 1);
    end
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 reset clears left_data", left_data, 0);
    chk("R9 reset clears right_data", right_data, 0);
    chk("R8 strobes wider than one cycle", wide, 0);
    chk("R8 simultaneous strobes", both, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule